// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block collects one-cycle event pulses from a fixed set of interrupt sources and holds each in a sticky pending bit. Every source has an enable bit and a two-bit level code. The controller picks one winner each cycle and presents it to the processor on a valid/ready pair. A small group of non-maskable inputs overrides all leveled sources.

The winner is chosen in this order. Pending non-maskable inputs come first, lowest index first. Next comes the highest level among pending, enabled sources. Within one level, the lowest index wins. The processor accepts the presented interrupt by holding `irq_ready` high while `irq_valid` is high. That handshake clears the named pending bit in the same edge.

Back-pressure does not freeze the output. The output is re-arbitrated on every clock, so while `irq_ready` is low a newly pending higher-priority source may replace the presented one. Only the pair seen at the accepting edge is acknowledged.

Software uses a small register port. It can read and write the pending bits directly, clear bits atomically with an AND mask, and program the enables and level codes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A one-cycle high on `src_pulse[i]` sets pending bit i at that edge, and the bit stays set until it is cleared by acknowledge or by software.
- R2: Only sources that are pending, enabled and have a non-zero level code compete. Level code 0 means off, and codes 1, 2 and 3 select the priority level. Disabled sources still latch their pending bits, and those bits can be read.
- R3: Any competing level-3 source beats any level-2 source, and level 2 beats level 1.
- R4: Among competing sources of the same level, the lowest index wins.
- R5: The non-maskable inputs are latched like sources and beat every leveled source, lowest index first. While one is presented, `irq_nmi` is 1 and `irq_index` is its number. Acknowledging it clears it.
- R6: `irq_valid`, `irq_nmi` and `irq_index` are registered and reflect the state that follows each edge. When `irq_valid` and `irq_ready` are both high at an edge, the presented pending bit is cleared.
- R7: Writing address 0 loads the pending register. Each 0 bit clears a request and each 1 bit raises one.
- R8: Writing address 1 ANDs the pending register with the write data in a single cycle. Bits of the mask that are 1 keep their state.
- R9: A hardware pulse in the same cycle as a software clear of that bit (address 0 or 1) leaves the bit set.
- R10: A pulse and an acknowledge of the same source in the same cycle leave the bit set.
- R11: After reset, pending bits, enables, level codes and the non-maskable latches are all 0, and `irq_valid` is 0.
- R12: `reg_rdata` shows the register selected by `reg_addr`, zero-extended: address 0 or 1 gives pending, 2 gives enables, 3 gives the level field. Source i's level code sits at bits 2i+1:2i of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | One-cycle event pulses from the leveled sources |
| nmi_pulse | input | NUM_NMI | One-cycle event pulses from the non-maskable inputs |
| irq_valid | output | 1 | An interrupt is presented |
| irq_nmi | output | 1 | The presented interrupt is non-maskable |
| irq_index | output | IDX_W | Index of the presented source |
| irq_ready | input | 1 | Processor accepts the presented interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 AND mask, 2 enable, 3 level |
| reg_wdata | input | 2*NUM_SRC | Write data |
| reg_rdata | output | 2*NUM_SRC | Read data for the selected register |

## Verification
The bench forces collisions between hardware pulses, acknowledges and software writes on the same pending bit in one cycle. It does this in directed cases: an AND mask that clears a bit while that bit pulses, and an accept of a source while it pulses again. It also does it across thousands of random cycles with sparse pulses, random writes and a random ready line. Each cycle, a behavioural model applies software, then acknowledge, then hardware set. The bench compares the pending readback and the presented winner against that model, so a lost event or a wrongly kept bit shows up on the next edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_ANDM = 2'd1,
    REG_ENAB = 2'd2,
    REG_LEVL = 2'd3
  } reg_sel_e;

  localparam logic [1:0] LVL_OFF = 2'd0;
  localparam int NUM_LEVELS = 3;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_NMI = 3,
  parameter int IW      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_pulse,
  input  logic [NUM_NMI-1:0]   nmi_pulse,
  input  logic                 ack_fire,
  input  logic                 ack_nmi,
  input  logic [IW-1:0]        ack_idx,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [2*NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0]   pend_q,
  output logic [NUM_NMI-1:0]   nmi_q,
  output logic [NUM_SRC-1:0]   en_q,
  output logic [2*NUM_SRC-1:0] lvl_q,
  output logic [NUM_SRC-1:0]   pend_d,
  output logic [NUM_NMI-1:0]   nmi_d,
  output logic [NUM_SRC-1:0]   en_d,
  output logic [2*NUM_SRC-1:0] lvl_d
);
  reg_sel_e sel;
  logic [NUM_SRC-1:0] sw_pend;
  logic [NUM_SRC-1:0] ack_src_mask;
  logic [NUM_NMI-1:0] ack_nmi_mask;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    ack_src_mask = '0;
    ack_nmi_mask = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (ack_fire && !ack_nmi && ack_idx == IW'(i)) ack_src_mask[i] = 1'b1;
    for (int j = 0; j < NUM_NMI; j++)
      if (ack_fire && ack_nmi && ack_idx == IW'(j)) ack_nmi_mask[j] = 1'b1;
  end

  // software first, then acknowledge, then hardware set (set always wins)
  always_comb begin
    sw_pend = pend_q;
    if (reg_wr && sel == REG_PEND) sw_pend = reg_wdata[NUM_SRC-1:0];
    if (reg_wr && sel == REG_ANDM) sw_pend = pend_q & reg_wdata[NUM_SRC-1:0];
    pend_d = (sw_pend & ~ack_src_mask) | src_pulse;
    nmi_d  = (nmi_q & ~ack_nmi_mask) | nmi_pulse;
    en_d   = (reg_wr && sel == REG_ENAB) ? reg_wdata[NUM_SRC-1:0] : en_q;
    lvl_d  = (reg_wr && sel == REG_LEVL) ? reg_wdata : lvl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      nmi_q  <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
      en_q   <= en_d;
      lvl_q  <= lvl_d;
    end
  end

  assert_pulse_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

  assert_nmi_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_pulse) |=> ((nmi_q & $past(nmi_pulse)) == $past(nmi_pulse)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_NMI = 3,
  parameter int IW      = 4
) (
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_NMI-1:0]   nmi,
  input  logic [NUM_SRC-1:0]   en,
  input  logic [2*NUM_SRC-1:0] lvl,
  output logic                 win_valid,
  output logic                 win_nmi,
  output logic [IW-1:0]        win_idx
);
  logic [NUM_LEVELS:1] lvl_hit;
  logic [IW-1:0]       lvl_idx [1:NUM_LEVELS];
  logic                nmi_hit;
  logic [IW-1:0]       nmi_idx;

  for (genvar L = 1; L <= NUM_LEVELS; L++) begin : g_level
    logic [NUM_SRC-1:0] bank;
    always_comb begin
      for (int i = 0; i < NUM_SRC; i++)
        bank[i] = pend[i] & en[i] & (lvl[2*i +: 2] == 2'(L));
    end
    irq_first_set #(.W(NUM_SRC), .IW(IW)) u_pick (
      .vec (bank),
      .hit (lvl_hit[L]),
      .idx (lvl_idx[L])
    );
  end

  irq_first_set #(.W(NUM_NMI), .IW(IW)) u_nmi_pick (
    .vec (nmi),
    .hit (nmi_hit),
    .idx (nmi_idx)
  );

  always_comb begin
    win_valid = 1'b0;
    win_nmi   = 1'b0;
    win_idx   = '0;
    if (nmi_hit) begin
      win_valid = 1'b1;
      win_nmi   = 1'b1;
      win_idx   = nmi_idx;
    end else begin
      for (int L = 1; L <= NUM_LEVELS; L++) begin
        if (lvl_hit[L]) begin
          win_valid = 1'b1;
          win_idx   = lvl_idx[L];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_NMI = 3,
  localparam int MAXN  = (NUM_SRC > NUM_NMI) ? NUM_SRC : NUM_NMI,
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int DW    = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [NUM_NMI-1:0] nmi_pulse,
  output logic               irq_valid,
  output logic               irq_nmi,
  output logic [IDX_W-1:0]   irq_index,
  input  logic               irq_ready,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata
);
  logic [NUM_SRC-1:0] pend_q, pend_d, en_q, en_d;
  logic [NUM_NMI-1:0] nmi_q, nmi_d;
  logic [DW-1:0]      lvl_q, lvl_d;
  logic               ack_fire;
  logic               win_valid, win_nmi;
  logic [IDX_W-1:0]   win_idx;

  assign ack_fire = irq_valid & irq_ready;

  irq_state_regs #(.NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .IW(IDX_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .nmi_pulse (nmi_pulse),
    .ack_fire  (ack_fire),
    .ack_nmi   (irq_nmi),
    .ack_idx   (irq_index),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_q    (pend_q),
    .nmi_q     (nmi_q),
    .en_q      (en_q),
    .lvl_q     (lvl_q),
    .pend_d    (pend_d),
    .nmi_d     (nmi_d),
    .en_d      (en_d),
    .lvl_d     (lvl_d)
  );

  // arbitrate on next state so the registered output matches the state after the edge
  irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .IW(IDX_W)) u_arb (
    .pend      (pend_d),
    .nmi       (nmi_d),
    .en        (en_d),
    .lvl       (lvl_d),
    .win_valid (win_valid),
    .win_nmi   (win_nmi),
    .win_idx   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_nmi   <= 1'b0;
      irq_index <= '0;
    end else begin
      irq_valid <= win_valid;
      irq_nmi   <= win_nmi;
      irq_index <= win_idx;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      REG_PEND, REG_ANDM: reg_rdata = DW'(pend_q);
      REG_ENAB:           reg_rdata = DW'(en_q);
      default:            reg_rdata = lvl_q;
    endcase
  end

  assert_nmi_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_q) |-> (irq_valid && irq_nmi));

  assert_served_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_nmi) |-> (pend_q[irq_index] && en_q[irq_index]
                                 && lvl_q[2*irq_index +: 2] != LVL_OFF));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !irq_nmi && !src_pulse[irq_index]
     && !(reg_wr && reg_addr == REG_PEND)) |=> !pend_q[$past(irq_index)]);

  assert_pulse_beats_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !irq_nmi && src_pulse[irq_index]) |=> pend_q[$past(irq_index)]);

  assert_idle_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0 && nmi_q == '0) |-> !irq_valid);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int NS = 16;
  localparam int NN = 3;
  localparam int IW = 4;
  localparam int DW = 2 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_pulse = '0;
  logic [NN-1:0] nmi_pulse = '0;
  logic          irq_valid, irq_nmi;
  logic [IW-1:0] irq_index;
  logic          irq_ready = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NS-1:0] m_pend = '0, m_en = '0;
  logic [NN-1:0] m_nmi = '0;
  logic [DW-1:0] m_lvl = '0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NS), .NUM_NMI(NN)) u_irq_prio_ctrl (
    .clk, .rst_n, .src_pulse, .nmi_pulse, .irq_valid, .irq_nmi, .irq_index,
    .irq_ready, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_arb(output bit v, output bit n, output int idx);
    v = 0; n = 0; idx = 0;
    for (int j = NN - 1; j >= 0; j--) if (m_nmi[j]) begin v = 1; n = 1; idx = j; end
    if (v) return;
    for (int L = 3; L >= 1 && !v; L--)
      for (int i = NS - 1; i >= 0; i--)
        if (m_pend[i] && m_en[i] && m_lvl[2*i +: 2] == 2'(L)) begin v = 1; idx = i; end
  endfunction

  task automatic model_step();
    bit v, n; int idx;
    logic [NS-1:0] p;
    model_arb(v, n, idx);
    p = m_pend;
    if (reg_wr && reg_addr == 2'd0) p = reg_wdata[NS-1:0];
    if (reg_wr && reg_addr == 2'd1) p = p & reg_wdata[NS-1:0];
    if (v && irq_ready && !n) p[idx] = 1'b0;
    if (v && irq_ready && n) m_nmi[idx] = 1'b0;
    m_pend = p | src_pulse;
    m_nmi  = m_nmi | nmi_pulse;
    if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[NS-1:0];
    if (reg_wr && reg_addr == 2'd3) m_lvl = reg_wdata;
  endtask

  task automatic compare();
    bit v, n; int idx;
    logic [DW-1:0] rexp;
    model_arb(v, n, idx);
    chk("R6 valid", irq_valid, v);
    if (v) begin
      chk("R5 nmi flag", irq_nmi, n);
      chk("R3 R4 winner", irq_index, idx);
    end
    case (reg_addr)
      2'd0, 2'd1: rexp = DW'(m_pend);
      2'd2:       rexp = DW'(m_en);
      default:    rexp = m_lvl;
    endcase
    chk("R12 readback", reg_rdata, rexp);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    src_pulse = '0; nmi_pulse = '0; reg_wr = 1'b0; irq_ready = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd_pend(string tag, logic [NS-1:0] exp);
    reg_addr = 2'd0; #0.1;
    chk(tag, reg_rdata, DW'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid after reset", irq_valid, 0);
    rd_pend("R11 pending after reset", '0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd3, 32'hAAAA_AAAA); tick();          // every source level 2
    wr(2'd2, 32'h0000_FFFF); tick();
    src_pulse = 16'h0220; tick();
    chk("R4 lowest index in level", irq_index, 5);
    rd_pend("R1 pulses latched", 16'h0220);
    wr(2'd3, 32'hAAAE_AAAA); tick();          // source 9 to level 3
    chk("R3 level 3 beats level 2", irq_index, 9);
    irq_ready = 1'b1; tick();
    chk("R6 ack moves to next", irq_index, 5);
    rd_pend("R6 ack clears bit", 16'h0020);
    nmi_pulse = 3'b010; tick();
    chk("R5 nmi presented", {irq_nmi, irq_index}, {1'b1, 4'd1});
    irq_ready = 1'b1; tick();
    chk("R5 nmi acked", {irq_nmi, irq_index}, {1'b0, 4'd5});
    wr(2'd2, 32'h0000_FFDF); tick();
    chk("R2 disabled not served", irq_valid, 0);
    rd_pend("R2 disabled still pending", 16'h0020);
    wr(2'd0, 32'h0000_0101); tick();
    rd_pend("R7 direct write", 16'h0101);
    chk("R7 raised irq served", irq_index, 0);
    wr(2'd1, 32'h0000_FFFE); src_pulse = 16'h0001; tick();
    rd_pend("R9 pulse beats clear", 16'h0101);
    wr(2'd1, 32'h0000_FEFF); src_pulse = 16'h0004; tick();
    rd_pend("R8 and mask", 16'h0005);
    irq_ready = 1'b1; src_pulse = 16'h0001; tick();
    rd_pend("R10 pulse beats ack", 16'h0005);
    chk("R10 still presented", irq_index, 0);
    wr(2'd3, 32'h0000_0000); tick();
    chk("R2 level 0 off", irq_valid, 0);

    for (int c = 0; c < 4000; c++) begin
      src_pulse = NS'($urandom & $urandom & $urandom);
      if ($urandom_range(15) == 0) nmi_pulse = NN'(1 << $urandom_range(NN - 1));
      irq_ready = $urandom_range(1);
      reg_addr = 2'($urandom_range(3));
      reg_wr = ($urandom_range(5) == 0);
      reg_wdata = $urandom;
      if (reg_wr && reg_addr == 2'd2) reg_wdata = reg_wdata | 32'h0000_F0F0;
      tick();
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule